// File: doc/BRIEF.md
# Transactional Read/Write-Set Tracker

This block is a small direct-mapped tag store for one core, where each line also carries a transactional read flag and a transactional write flag. Updates made inside a transaction stay local to the cache (lazy versioning). Conflicts are only found when another core commits and its invalidations are snooped (lazy conflict detection). No data array is kept. Each line holds only a valid bit, a dirty bit, a tag and the two tracking flags. A miss fills the line at once in the clean, read-only condition.

Software opens a transaction with a begin strobe and issues loads and stores as line addresses. It closes the transaction with an end strobe. At the end the block scans every index once. It presents the full line address of each speculatively written line as a stream, which the bus logic broadcasts as invalidations. The block aborts the transaction in three cases: a snooped invalidation hits a tracked line, a speculatively written line is evicted, or a miss would displace one. When it aborts, it drops the speculative lines and clears all tracking in a single cycle. A combinational lookup of the request address reports hit and dirty status, so the state of any line can be seen at the ports.

Line addresses are split into a low index field of `INDEX_W` bits and a tag made of the remaining upper bits. With the defaults there are 8 lines and 12-bit line addresses.

Top module: `txn_set_tracker`

## Requirements
- R1: After reset no line is valid (`lookupHit` low for any address), `txnOpen` is low, and `abortOut`, `overflowOut`, `commitValid` and `commitDone` are low.
- R2: A transactional load that misses fills its line clean. The line reports a hit with `lookupDirty` low from the next cycle, and it joins the read-set.
- R3: A transactional store fills its line if it is absent and puts the line in the write-set. The line reports a hit, and `lookupDirty` stays low until the transaction commits.
- R4: Loads and stores outside a transaction set no tracking flag. A store outside a transaction sets `lookupDirty` on the next cycle.
- R5: Inside an open transaction, a snooped line address that hits a line in the read-set or write-set raises `abortOut` for exactly one cycle after the snoop's edge, with `overflowOut` low. `txnOpen` is low in that same cycle.
- R6: A snoop that hits an untracked line, or any snoop while no transaction is open, only invalidates that line. It does not abort.
- R7: Inside a transaction, two events raise `overflowOut` and `abortOut` together for one cycle: an eviction of an index whose line is in the write-set, or a miss whose victim line is in the write-set. The missing line is not filled.
- R8: After an abort, lines from the write-set are invalid, lines only in the read-set remain valid, and every tracking flag is clear.
- R9: `txEnd` starts a walk of exactly `LINES` cycles over indices in ascending order. `commitValid` is high once per write-set line, with `commitLine` equal to that line's full address. `commitDone` pulses on the cycle after the walk.
- R10: After commit, the written lines are valid with `lookupDirty` high, and all tracking flags are clear.
- R11: During the commit walk, snoops, evictions and load/store requests are ignored.
- R12: If an abort cause arrives on the same edge as `txEnd`, the abort wins: no walk starts and `commitDone` stays low.
- R13: `txBegin` while no transaction is open raises `txnOpen` on the next cycle. `txnOpen` stays high until an abort or the end of the commit walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| txBegin | input | 1 | Open a transaction |
| txEnd | input | 1 | Close the transaction and commit |
| reqValid | input | 1 | Load/store request strobe |
| reqWrite | input | 1 | Request is a store |
| reqLine | input | LINE_W | Request line address, also the lookup address |
| snoopValid | input | 1 | Snooped invalidation strobe |
| snoopLine | input | LINE_W | Snooped line address |
| evictValid | input | 1 | Eviction of one index |
| evictIndex | input | INDEX_W | Index being evicted |
| lookupHit | output | 1 | `reqLine` is present |
| lookupDirty | output | 1 | `reqLine` is present and dirty |
| txnOpen | output | 1 | Transaction open or committing |
| abortOut | output | 1 | One-cycle abort pulse |
| overflowOut | output | 1 | Abort was caused by overflow |
| commitValid | output | 1 | `commitLine` carries a write-set line |
| commitLine | output | LINE_W | Line address being committed |
| commitDone | output | 1 | Commit walk finished |

## Verification
The bound checker checks the following on every cycle: the pulse shapes, overflow implying abort, aborts only leaving an open transaction and closing it, commit output only while the transaction is open, and begin opening a closed transaction. The bench's directed scenarios are needed for the rest: which lines are invalidated or kept after an abort, the dirty promotion at commit, the order and addresses of the commit stream, and the window in which commit ignores snoops and requests. Only a sequence of stores, snoops and lookups can show these.

// File: rtl/txs_pkg.sv
package txs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TXN    = 2'd1,
    ST_COMMIT = 2'd2
  } txState_e;

  // Strobes from the sequencer to the line store.
  typedef struct packed {
    logic accFill;   // allocate request line (miss)
    logic setRd;     // add request line to read-set
    logic setWr;     // add request line to write-set
    logic setDirty;  // non-speculative store
    logic snoopInv;  // apply snooped invalidation
    logic evictInv;  // drop evicted index
    logic abortClr;  // discard speculative state
    logic commitClr; // publish write-set, clear tracking
  } txStrobe_t;

endpackage

// File: rtl/txs_line_store.sv
module txs_line_store
  import txs_pkg::*;
#(
  parameter int LINE_W  = 12,
  parameter int INDEX_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  txStrobe_t          strobe,
  input  logic [LINE_W-1:0]  reqLine,
  input  logic [LINE_W-1:0]  snoopLine,
  input  logic [INDEX_W-1:0] evictIndex,
  input  logic [INDEX_W-1:0] walkIdx,
  output logic               reqHit,
  output logic               reqDirty,
  output logic               reqVictimWr,
  output logic               snoopHit,
  output logic               snoopTracked,
  output logic               evictWr,
  output logic               walkWr,
  output logic [LINE_W-1:0]  walkLine
);

  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = LINE_W - INDEX_W;

  logic [TAG_W-1:0] tagMem [LINES];
  logic [LINES-1:0] validV, dirtyV, rdV, wrV;
  logic [LINES-1:0] validN, dirtyN, rdN, wrN;

  logic [INDEX_W-1:0] rIdx, sIdx;
  logic [TAG_W-1:0]   rTag, sTag;

  assign rIdx = reqLine[INDEX_W-1:0];
  assign rTag = reqLine[LINE_W-1:INDEX_W];
  assign sIdx = snoopLine[INDEX_W-1:0];
  assign sTag = snoopLine[LINE_W-1:INDEX_W];

  assign reqHit       = validV[rIdx] && (tagMem[rIdx] == rTag);
  assign reqDirty     = reqHit && dirtyV[rIdx];
  assign reqVictimWr  = wrV[rIdx];
  assign snoopHit     = validV[sIdx] && (tagMem[sIdx] == sTag);
  assign snoopTracked = rdV[sIdx] || wrV[sIdx];
  assign evictWr      = wrV[evictIndex];
  assign walkWr       = wrV[walkIdx];
  assign walkLine     = {tagMem[walkIdx], walkIdx};

  // Next-state of the flag vectors; whole-vector operations are flash clears.
  always_comb begin
    validN = validV;
    dirtyN = dirtyV;
    rdN    = rdV;
    wrN    = wrV;
    if (strobe.snoopInv && snoopHit) begin
      validN[sIdx] = 1'b0;
      dirtyN[sIdx] = 1'b0;
    end
    if (strobe.evictInv) begin
      validN[evictIndex] = 1'b0;
      dirtyN[evictIndex] = 1'b0;
      rdN[evictIndex]    = 1'b0;
      wrN[evictIndex]    = 1'b0;
    end
    if (strobe.abortClr) begin
      validN = validN & ~wrV;
      rdN    = '0;
      wrN    = '0;
    end
    if (strobe.commitClr) begin
      dirtyN = dirtyN | wrV;
      rdN    = '0;
      wrN    = '0;
    end
    if (strobe.accFill) begin
      validN[rIdx] = 1'b1;
      dirtyN[rIdx] = 1'b0;
      rdN[rIdx]    = 1'b0;
      wrN[rIdx]    = 1'b0;
    end
    if (strobe.setRd)    rdN[rIdx]    = 1'b1;
    if (strobe.setWr)    wrN[rIdx]    = 1'b1;
    if (strobe.setDirty) dirtyN[rIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validV <= '0;
      dirtyV <= '0;
      rdV    <= '0;
      wrV    <= '0;
    end else begin
      validV <= validN;
      dirtyV <= dirtyN;
      rdV    <= rdN;
      wrV    <= wrN;
    end
  end

  // Tags carry no reset; the valid vector qualifies them.
  always_ff @(posedge clk) begin
    if (strobe.accFill) tagMem[rIdx] <= rTag;
  end

endmodule

// File: rtl/txs_seq_ctrl.sv
module txs_seq_ctrl
  import txs_pkg::*;
#(
  parameter int INDEX_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txBegin,
  input  logic               txEnd,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic               snoopValid,
  input  logic               evictValid,
  input  logic               reqHit,
  input  logic               reqVictimWr,
  input  logic               snoopHit,
  input  logic               snoopTracked,
  input  logic               evictWr,
  output txStrobe_t          strobe,
  output logic [INDEX_W-1:0] walkIdx,
  output logic               inCommit,
  output logic               txnOpen,
  output logic               abortOut,
  output logic               overflowOut,
  output logic               commitDone
);

  localparam logic [INDEX_W-1:0] LAST_IDX = '1;

  txState_e state, stateN;
  logic inTxn, snoopConflict, evictOvf, fillOvf, abortNow, accept, walkEnd;

  assign inTxn    = (state == ST_TXN);
  assign inCommit = (state == ST_COMMIT);
  assign txnOpen  = (state != ST_IDLE);
  assign walkEnd  = inCommit && (walkIdx == LAST_IDX);

  assign snoopConflict = inTxn && snoopValid && snoopHit && snoopTracked;
  assign evictOvf      = inTxn && evictValid && evictWr;
  assign fillOvf       = inTxn && reqValid && !reqHit && reqVictimWr;
  assign abortNow      = snoopConflict || evictOvf || fillOvf;

  assign accept = reqValid && ((state == ST_IDLE) || (inTxn && !abortNow));

  always_comb begin
    strobe           = '0;
    strobe.accFill   = accept && !reqHit;
    strobe.setRd     = accept && inTxn && !reqWrite;
    strobe.setWr     = accept && inTxn && reqWrite;
    strobe.setDirty  = accept && !inTxn && reqWrite;
    strobe.snoopInv  = snoopValid && !inCommit;
    strobe.evictInv  = evictValid && !inCommit;
    strobe.abortClr  = abortNow;
    strobe.commitClr = walkEnd;
  end

  always_comb begin
    stateN = state;
    unique case (state)
      ST_IDLE:   if (txBegin) stateN = ST_TXN;
      ST_TXN:    if (abortNow) stateN = ST_IDLE;
                 else if (txEnd) stateN = ST_COMMIT;
      ST_COMMIT: if (walkEnd) stateN = ST_IDLE;
      default:   stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      walkIdx     <= '0;
      abortOut    <= 1'b0;
      overflowOut <= 1'b0;
      commitDone  <= 1'b0;
    end else begin
      state       <= stateN;
      abortOut    <= abortNow;
      overflowOut <= evictOvf || fillOvf;
      commitDone  <= walkEnd;
      if (inCommit) walkIdx <= walkIdx + 1'b1;
      else          walkIdx <= '0;
    end
  end

endmodule

// File: rtl/txn_set_tracker.sv
module txn_set_tracker
  import txs_pkg::*;
#(
  parameter int LINE_W  = 12,
  parameter int INDEX_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txBegin,
  input  logic               txEnd,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [LINE_W-1:0]  reqLine,
  input  logic               snoopValid,
  input  logic [LINE_W-1:0]  snoopLine,
  input  logic               evictValid,
  input  logic [INDEX_W-1:0] evictIndex,
  output logic               lookupHit,
  output logic               lookupDirty,
  output logic               txnOpen,
  output logic               abortOut,
  output logic               overflowOut,
  output logic               commitValid,
  output logic [LINE_W-1:0]  commitLine,
  output logic               commitDone
);

  txStrobe_t          strobe;
  logic [INDEX_W-1:0] walkIdx;
  logic reqVictimWr, snoopHit, snoopTracked, evictWr, walkWr, inCommit;

  txs_seq_ctrl #(.INDEX_W(INDEX_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .txBegin      (txBegin),
    .txEnd        (txEnd),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .snoopValid   (snoopValid),
    .evictValid   (evictValid),
    .reqHit       (lookupHit),
    .reqVictimWr  (reqVictimWr),
    .snoopHit     (snoopHit),
    .snoopTracked (snoopTracked),
    .evictWr      (evictWr),
    .strobe       (strobe),
    .walkIdx      (walkIdx),
    .inCommit     (inCommit),
    .txnOpen      (txnOpen),
    .abortOut     (abortOut),
    .overflowOut  (overflowOut),
    .commitDone   (commitDone)
  );

  txs_line_store #(.LINE_W(LINE_W), .INDEX_W(INDEX_W)) u_store (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqLine      (reqLine),
    .snoopLine    (snoopLine),
    .evictIndex   (evictIndex),
    .walkIdx      (walkIdx),
    .reqHit       (lookupHit),
    .reqDirty     (lookupDirty),
    .reqVictimWr  (reqVictimWr),
    .snoopHit     (snoopHit),
    .snoopTracked (snoopTracked),
    .evictWr      (evictWr),
    .walkWr       (walkWr),
    .walkLine     (commitLine)
  );

  assign commitValid = inCommit && walkWr;

endmodule

// File: rtl/txs_checker.sv
module txs_checker (
  input logic clk,
  input logic rstN,
  input logic txBegin,
  input logic txnOpen,
  input logic abortOut,
  input logic overflowOut,
  input logic commitValid,
  input logic commitDone
);

  AST_OVF_IMPLIES_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    overflowOut |-> abortOut); // R7

  AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    abortOut |-> !txnOpen); // R5

  AST_ABORT_FROM_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    abortOut |-> $past(txnOpen)); // R5

  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    abortOut |=> !abortOut); // R5

  AST_COMMIT_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> txnOpen); // R9

  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |-> (!txnOpen && !commitValid && !abortOut)); // R10

  AST_BEGIN_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (txBegin && !txnOpen) |=> txnOpen); // R13

endmodule

bind txn_set_tracker txs_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .txBegin     (txBegin),
  .txnOpen     (txnOpen),
  .abortOut    (abortOut),
  .overflowOut (overflowOut),
  .commitValid (commitValid),
  .commitDone  (commitDone)
);

// File: tb/txn_set_tracker_tb.sv
`timescale 1ns/1ps
module txn_set_tracker_tb;

  localparam int LINE_W  = 12;
  localparam int INDEX_W = 3;
  localparam int LINES   = 1 << INDEX_W;

  // Line address = {tag, index}; index is the low INDEX_W bits.
  localparam logic [LINE_W-1:0] LA = 12'h011; // index 1
  localparam logic [LINE_W-1:0] LB = 12'h022; // index 2
  localparam logic [LINE_W-1:0] LC = 12'h033; // index 3
  localparam logic [LINE_W-1:0] LD = 12'h0A1; // index 1, other tag

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txBegin = 0, txEnd = 0, reqValid = 0, reqWrite = 0;
  logic snoopValid = 0, evictValid = 0;
  logic [LINE_W-1:0]  reqLine = '0, snoopLine = '0;
  logic [INDEX_W-1:0] evictIndex = '0;
  logic lookupHit, lookupDirty, txnOpen, abortOut, overflowOut;
  logic commitValid, commitDone;
  logic [LINE_W-1:0] commitLine;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [LINE_W-1:0] gotLines [LINES];
  int gotN;
  int walkCycles;
  bit sawAbort;

  always #2 clk = ~clk;

  txn_set_tracker #(.LINE_W(LINE_W), .INDEX_W(INDEX_W)) u_dut (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic peek(input logic [LINE_W-1:0] line, output logic hit, output logic dirty);
    reqLine = line; #1;
    hit = lookupHit; dirty = lookupDirty;
  endtask

  task automatic access(input logic wr, input logic [LINE_W-1:0] line);
    reqValid = 1; reqWrite = wr; reqLine = line;
    cyc();
    reqValid = 0; reqWrite = 0;
  endtask

  task automatic snoop(input logic [LINE_W-1:0] line);
    snoopValid = 1; snoopLine = line;
    cyc();
    snoopValid = 0;
  endtask

  task automatic beginTxn();
    txBegin = 1; cyc(); txBegin = 0;
  endtask

  // Ends the transaction and gathers the commit stream; optionally disturbs
  // the first walk cycle with a snoop, an eviction and a store.
  task automatic endTxn(input bit disturb, input logic [LINE_W-1:0] dLine,
                        input logic [INDEX_W-1:0] dIdx);
    gotN = 0; walkCycles = 0; sawAbort = 0;
    txEnd = 1; cyc(); txEnd = 0;
    while (!commitDone && walkCycles < 4 * LINES) begin
      if (commitValid) begin gotLines[gotN] = commitLine; gotN++; end
      if (abortOut) sawAbort = 1;
      if (disturb && walkCycles == 0) begin
        snoopValid = 1; snoopLine = dLine;
        evictValid = 1; evictIndex = dIdx;
        reqValid = 1; reqWrite = 1; reqLine = LD;
      end
      cyc();
      snoopValid = 0; evictValid = 0; reqValid = 0; reqWrite = 0;
      walkCycles++;
    end
  endtask

  task automatic t_reset();
    logic h, d;
    check("R1", "txnOpen", txnOpen, 0);
    check("R1", "abortOut", abortOut, 0);
    check("R1", "overflowOut", overflowOut, 0);
    check("R1", "commitValid", commitValid, 0);
    check("R1", "commitDone", commitDone, 0);
    peek(LA, h, d); check("R1", "hit A", h, 0);
    peek(LC, h, d); check("R1", "hit C", h, 0);
  endtask

  task automatic t_commit();
    logic h, d;
    beginTxn();
    check("R13", "txnOpen after begin", txnOpen, 1);
    access(0, LA);
    peek(LA, h, d); check("R2", "read fills hit", h, 1); check("R2", "read clean", d, 0);
    access(1, LC);
    access(1, LB);
    peek(LB, h, d); check("R3", "write hit", h, 1); check("R3", "write not dirty yet", d, 0);
    check("R13", "still open", txnOpen, 1);
    endTxn(0, '0, '0);
    check("R9", "walk cycles", walkCycles, LINES);
    check("R9", "commit count", gotN, 2);
    check("R9", "first line B", gotLines[0], LB);
    check("R9", "second line C", gotLines[1], LC);
    check("R9", "no abort", sawAbort, 0);
    check("R13", "closed after commit", txnOpen, 0);
    cyc();
    check("R9", "done single pulse", commitDone, 0);
    peek(LB, h, d); check("R10", "B valid", h, 1); check("R10", "B dirty", d, 1);
    peek(LC, h, d); check("R10", "C dirty", d, 1);
    peek(LA, h, d); check("R10", "A clean", d, 0);
    // Read flag on A must be gone: a snoop in a new transaction is harmless.
    beginTxn();
    snoop(LA);
    check("R10", "no abort on old read line", abortOut, 0);
    check("R10", "txn still open", txnOpen, 1);
    endTxn(0, '0, '0);
    check("R10", "empty commit", gotN, 0);
  endtask

  task automatic t_snoopAbort();
    logic h, d;
    beginTxn();
    access(0, LA);
    access(0, LC);
    access(1, LB);
    snoop(LA);
    check("R5", "abortOut", abortOut, 1);
    check("R5", "overflow low", overflowOut, 0);
    check("R5", "txn closed", txnOpen, 0);
    cyc();
    check("R5", "abort one cycle", abortOut, 0);
    peek(LB, h, d); check("R8", "written B dropped", h, 0);
    peek(LC, h, d); check("R8", "read C kept", h, 1); check("R8", "C keeps dirty", d, 1);
    beginTxn();
    snoop(LC);
    check("R8", "read flags cleared", abortOut, 0);
    peek(LC, h, d); check("R6", "untracked snoop invalidates", h, 0);
    endTxn(0, '0, '0);
    check("R8", "write flags cleared", gotN, 0);
  endtask

  task automatic t_overflow();
    logic h, d;
    beginTxn();
    access(1, LA);
    evictValid = 1; evictIndex = LA[INDEX_W-1:0]; cyc(); evictValid = 0;
    check("R7", "evict overflow", overflowOut, 1);
    check("R7", "evict abort", abortOut, 1);
    peek(LA, h, d); check("R7", "A gone", h, 0);
    beginTxn();
    access(1, LA);
    access(0, LD);
    check("R7", "victim overflow", overflowOut, 1);
    check("R7", "victim abort", abortOut, 1);
    peek(LD, h, d); check("R7", "D not filled", h, 0);
    peek(LA, h, d); check("R8", "A invalid", h, 0);
  endtask

  task automatic t_outside();
    logic h, d;
    snoop(LB);
    access(1, LC);
    peek(LC, h, d); check("R4", "plain store dirty", d, 1);
    access(0, LB);
    snoop(LC);
    check("R6", "idle snoop no abort", abortOut, 0);
    peek(LC, h, d); check("R6", "idle snoop invalidates", h, 0);
    beginTxn();
    snoop(LB);
    check("R4", "plain read untracked", abortOut, 0);
    check("R6", "open after untracked snoop", txnOpen, 1);
    endTxn(0, '0, '0);
    check("R4", "plain store untracked", gotN, 0);
  endtask

  task automatic t_commitWindow();
    logic h, d;
    beginTxn();
    access(0, LA);
    access(1, LC);
    endTxn(1, LA, LC[INDEX_W-1:0]);
    check("R11", "no abort in walk", sawAbort, 0);
    check("R11", "commit count", gotN, 1);
    check("R11", "commit C", gotLines[0], LC);
    peek(LA, h, d); check("R11", "A survives snoop/store", h, 1);
    peek(LC, h, d); check("R11", "C survives evict", h, 1); check("R10", "C dirty", d, 1);
  endtask

  task automatic t_abortVsEnd();
    beginTxn();
    access(0, LB);
    txEnd = 1; snoopValid = 1; snoopLine = LB;
    cyc();
    txEnd = 0; snoopValid = 0;
    check("R12", "abort wins", abortOut, 1);
    check("R12", "closed", txnOpen, 0);
    for (int i = 0; i < LINES + 2; i++) begin
      if (commitDone || commitValid) begin
        check("R12", "no commit output", 1, 0);
      end
      cyc();
    end
    check("R12", "still closed", txnOpen, 0);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    t_reset();
    rstN = 1;
    cyc();
    t_reset();
    t_commit();
    t_snoopAbort();
    t_overflow();
    t_outside();
    t_commitWindow();
    t_abortVsEnd();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule